// File: doc/BRIEF.md
# Banked Clock Fanout with Per-Bank Halving

This block takes a single input clock and spreads it over a parameterized number of output banks. Each bank holds several outputs that all carry the same waveform. Each bank has its own rate select. It can pass the input clock through at full rate, or it can drive a half-rate clock from one toggle register that all banks share. That register changes on the input rising edge, so every half-rate rising edge falls on a full-rate rising edge.

A small count code chooses how many banks run. The first bank always runs, and each higher code value adds the next bank in order. An active-low hold input overrides everything. While it is low, it clears the shared halving register and turns every output driver off. Releasing it restarts the halving phase on a known edge. Each output is presented to the pad ring as a data bit plus a driver-enable bit. A cleared enable means the pad floats, and the data bit of a disabled output is held at 0.

Top module: `clk_fanout_banks`

## Requirements
- R1: All outputs of one bank carry identical waveforms and identical driver enables at every instant.
- R2: A bank whose rate select bit is 1 follows the input clock. It is high during the input high phase and low during the input low phase, giving one rising edge per input cycle.
- R3: A bank whose rate select bit is 0 runs at half the input rate, giving one rising edge every two input cycles. Its level changes only on an input rising edge.
- R4: While hold_n is 0, every fan_oe bit and every fan_clk bit is 0, asynchronously, whatever the other inputs are.
- R5: With hold_n at 1, bank b (bank 0 to bank 3, bank 0 on the lowest fan_clk bits) is enabled exactly when the unsigned count code bank_cnt_sel is at least b. Code 0 enables bank 0 only, code 1 enables banks 0 and 1, code 2 enables banks 0 to 2, and code 3 enables all four.
- R6: The first input rising edge after hold_n goes high gives a rising edge on every enabled half-rate bank, on the same edge as the full-rate banks.
- R7: A disabled bank drives fan_oe 0 and fan_clk 0 for either rate select value.
- R8: Bank 0 is enabled whenever hold_n is 1, for every count code.
- R9: A change of a rate select bit takes effect at once, without a hold pulse. The bank shows the newly selected waveform in the same input phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be distributed |
| hold_n | input | 1 | Active-low clear of the halving register and global driver disable |
| bank_cnt_sel | input | 2 | Count code for how many banks run (cumulative from bank 0) |
| rate_sel | input | 4 | Per-bank rate select, bit b for bank b: 1 full rate, 0 half rate |
| fan_clk | output | 20 | Output clock data, five bits per bank, bank 0 lowest |
| fan_oe | output | 20 | Pad driver enable per output, 0 means high impedance |

## Verification
A table of sixteen vectors walks every rate-select pattern. The count code rotates through its four values, so each bank is seen enabled at both rates and also disabled. This separates a wrong rate mux from a wrong enable decode. Both input phases are sampled. Rising edges are counted per output, and so are rising edges that show up in a low phase. Together these tell apart full rate, half rate, a half-rate clock on the wrong edge, and a wrongly gated bank. Directed cases apply hold in the middle of a run while the halving register is high, to show that it really clears. They also flip the rate selects while the clock runs, in both directions.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

   typedef enum logic {
      RATE_HALF = 1'b0,
      RATE_FULL = 1'b1
   } rate_e;

endpackage

// File: rtl/clkfan_div2.sv
module clkfan_div2 (
   input  logic clk_in,
   input  logic hold_n,
   output logic half_clk
);

   // Shared toggle: cleared while held, first toggle on the first rising
   // edge after release so the half-rate rise lines up with the input rise.
   always_ff @(posedge clk_in or negedge hold_n) begin
      if (!hold_n) half_clk <= 1'b0;
      else         half_clk <= ~half_clk;
   end

endmodule

// File: rtl/clkfan_en_decode.sv
module clkfan_en_decode #(
   parameter int NUM_BANKS = 4,
   parameter int CODE_W    = 2
) (
   input  logic                 hold_n,
   input  logic [CODE_W-1:0]    bank_cnt_sel,
   output logic [NUM_BANKS-1:0] bank_en
);

   localparam int IDX_W = CODE_W + 1;

   logic [IDX_W-1:0] code_ext;
   assign code_ext = {1'b0, bank_cnt_sel};

   // Cumulative (thermometer) decode: bank b runs once the code reaches b.
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
      localparam logic [IDX_W-1:0] BANK_IDX = IDX_W'(b);
      if (b == 0) begin : g_first
         assign bank_en[b] = hold_n;
      end else begin : g_rest
         assign bank_en[b] = hold_n & (code_ext >= BANK_IDX);
      end
   end

endmodule

// File: rtl/clkfan_bank.sv
module clkfan_bank #(
   parameter int OUTS = 5
) (
   input  logic                clk_in,
   input  logic                half_clk,
   input  clkfan_pkg::rate_e   rate,
   input  logic                en,
   output logic [OUTS-1:0]     q,
   output logic [OUTS-1:0]     q_en
);

   logic wave;

   always_comb begin
      if (!en)                              wave = 1'b0;
      else if (rate == clkfan_pkg::RATE_FULL) wave = clk_in;
      else                                  wave = half_clk;
   end

   for (genvar i = 0; i < OUTS; i++) begin : g_out
      assign q[i]    = wave;
      assign q_en[i] = en;
   end

endmodule

// File: rtl/clk_fanout_banks.sv
module clk_fanout_banks #(
   parameter  int NUM_BANKS     = 4,
   parameter  int OUTS_PER_BANK = 5,
   localparam int CODE_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int TOTAL_OUTS    = NUM_BANKS * OUTS_PER_BANK
) (
   input  logic                  clk_in,
   input  logic                  hold_n,
   input  logic [CODE_W-1:0]     bank_cnt_sel,
   input  logic [NUM_BANKS-1:0]  rate_sel,
   output logic [TOTAL_OUTS-1:0] fan_clk,
   output logic [TOTAL_OUTS-1:0] fan_oe
);

   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("clk_fanout_banks: NUM_BANKS must be at least 2");
   end
   if (OUTS_PER_BANK < 1) begin : g_bad_outs
      $error("clk_fanout_banks: OUTS_PER_BANK must be at least 1");
   end

   logic                 half_clk;
   logic [NUM_BANKS-1:0] bank_en;

   clkfan_div2 u_div (
      .clk_in   (clk_in),
      .hold_n   (hold_n),
      .half_clk (half_clk)
   );

   clkfan_en_decode #(
      .NUM_BANKS (NUM_BANKS),
      .CODE_W    (CODE_W)
   ) u_dec (
      .hold_n       (hold_n),
      .bank_cnt_sel (bank_cnt_sel),
      .bank_en      (bank_en)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      clkfan_bank #(
         .OUTS (OUTS_PER_BANK)
      ) u_bank (
         .clk_in   (clk_in),
         .half_clk (half_clk),
         .rate     (clkfan_pkg::rate_e'(rate_sel[b])),
         .en       (bank_en[b]),
         .q        (fan_clk[b*OUTS_PER_BANK +: OUTS_PER_BANK]),
         .q_en     (fan_oe[b*OUTS_PER_BANK +: OUTS_PER_BANK])
      );
   end

endmodule

// File: rtl/clkfan_chk.sv
module clkfan_chk #(
   parameter int NUM_BANKS     = 4,
   parameter int OUTS_PER_BANK = 5,
   parameter int TOTAL_OUTS    = 20
) (
   input logic                  clk_in,
   input logic                  hold_n,
   input logic [TOTAL_OUTS-1:0] fan_clk,
   input logic [TOTAL_OUTS-1:0] fan_oe,
   input logic                  half_clk
);

   logic uniform_ok;
   logic thermo_ok;
   logic off_low_ok;

   always_comb begin
      uniform_ok = 1'b1;
      off_low_ok = 1'b1;
      for (int b = 0; b < NUM_BANKS; b++) begin
         for (int i = 0; i < OUTS_PER_BANK; i++) begin
            if (fan_clk[b*OUTS_PER_BANK+i] != fan_clk[b*OUTS_PER_BANK] ||
                fan_oe[b*OUTS_PER_BANK+i]  != fan_oe[b*OUTS_PER_BANK])
               uniform_ok = 1'b0;
            if (!fan_oe[b*OUTS_PER_BANK+i] && fan_clk[b*OUTS_PER_BANK+i])
               off_low_ok = 1'b0;
         end
      end
   end

   always_comb begin
      thermo_ok = 1'b1;
      for (int b = 1; b < NUM_BANKS; b++) begin
         if (fan_oe[b*OUTS_PER_BANK] && !fan_oe[(b-1)*OUTS_PER_BANK])
            thermo_ok = 1'b0;
      end
   end

   // R1
   p_bank_uniform_r1: assert property (@(posedge clk_in) disable iff (!hold_n)
      uniform_ok);

   // R3
   p_half_toggles_r3: assert property (@(posedge clk_in) disable iff (!hold_n)
      1'b1 |=> (half_clk != $past(half_clk)));

   // R4
   always_comb begin
      if (!hold_n) begin
         p_quiet_r4: assert (fan_oe == '0 && fan_clk == '0);
      end
   end

   // R5
   p_thermometer_r5: assert property (@(posedge clk_in) disable iff (!hold_n)
      thermo_ok);

   // R6
   p_rephase_r6: assert property (@(posedge clk_in) disable iff (!hold_n)
      $rose(hold_n) |-> (!half_clk ##1 half_clk));

   // R7
   p_off_low_r7: assert property (@(posedge clk_in) disable iff (!hold_n)
      off_low_ok);

   // R8
   p_bank0_on_r8: assert property (@(posedge clk_in) disable iff (!hold_n)
      fan_oe[0]);

endmodule

bind clk_fanout_banks clkfan_chk #(
   .NUM_BANKS     (NUM_BANKS),
   .OUTS_PER_BANK (OUTS_PER_BANK),
   .TOTAL_OUTS    (TOTAL_OUTS)
) u_chk (
   .clk_in   (clk_in),
   .hold_n   (hold_n),
   .fan_clk  (fan_clk),
   .fan_oe   (fan_oe),
   .half_clk (half_clk)
);

// File: tb/tb_clk_fanout_banks.sv
`timescale 1ns/100ps
module tb_clk_fanout_banks;

   localparam int NB  = 4;
   localparam int NO  = 5;
   localparam int TOT = NB * NO;
   localparam int WIN = 8;

   // {rate_sel[3:0], bank_cnt_sel[1:0], expected enabled-bank mask[3:0]}
   localparam logic [9:0] VEC [16] = '{
      10'b0000_00_0001, 10'b0001_01_0011, 10'b0010_10_0111, 10'b0011_11_1111,
      10'b0100_00_0001, 10'b0101_01_0011, 10'b0110_10_0111, 10'b0111_11_1111,
      10'b1000_00_0001, 10'b1001_01_0011, 10'b1010_10_0111, 10'b1011_11_1111,
      10'b1100_00_0001, 10'b1101_01_0011, 10'b1110_10_0111, 10'b1111_11_1111
   };

   logic           clk_in = 1'b0;
   logic           hold_n = 1'b0;
   logic [1:0]     bank_cnt_sel = 2'd3;
   logic [NB-1:0]  rate_sel = '1;
   logic [TOT-1:0] fan_clk;
   logic [TOT-1:0] fan_oe;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   int   rises    [TOT];
   int   low_rise [TOT];
   int   bad_val  [TOT];
   int   diff     [TOT];
   logic prev     [TOT];

   always #2 clk_in = ~clk_in;   // 250 MHz

   clk_fanout_banks dut (
      .clk_in       (clk_in),
      .hold_n       (hold_n),
      .bank_cnt_sel (bank_cnt_sel),
      .rate_sel     (rate_sel),
      .fan_clk      (fan_clk),
      .fan_oe       (fan_oe)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_stats();
      for (int o = 0; o < TOT; o++) begin
         rises[o] = 0; low_rise[o] = 0; bad_val[o] = 0; diff[o] = 0; prev[o] = 1'b0;
      end
   endtask

   task automatic take(input bit hi, input int cyc, input logic [3:0] mask);
      for (int o = 0; o < TOT; o++) begin
         int   b;
         logic ev;
         b = o / NO;
         if (!mask[b])         ev = 1'b0;
         else if (rate_sel[b]) ev = hi;
         else                  ev = ((cyc % 2) == 0);
         if (fan_clk[o] != ev || fan_oe[o] != mask[b]) bad_val[o]++;
         if (fan_clk[o] != fan_clk[b*NO] || fan_oe[o] != fan_oe[b*NO]) diff[o]++;
         if (!prev[o] && fan_clk[o]) begin
            rises[o]++;
            if (!hi) low_rise[o]++;
         end
         prev[o] = fan_clk[o];
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      // Reset state, R4: hold low from time zero, both phases sampled
      for (int c = 0; c < 3; c++) begin
         @(posedge clk_in); #1;
         check(fan_oe == '0, "R4", "oe under hold (high phase)", fan_oe, 0);
         check(fan_clk == '0, "R4", "clk under hold (high phase)", fan_clk, 0);
         @(negedge clk_in); #1;
         check(fan_clk == '0, "R4", "clk under hold (low phase)", fan_clk, 0);
      end

      // Table walk: R1, R2, R3, R5, R6, R7, R8
      foreach (VEC[v]) begin
         logic [3:0] mask;
         mask = VEC[v][3:0];
         @(negedge clk_in); #0.5;
         hold_n = 1'b0;
         rate_sel = VEC[v][9:6];
         bank_cnt_sel = VEC[v][5:4];
         @(negedge clk_in); #0.5;
         hold_n = 1'b1;
         clear_stats();
         for (int c = 0; c < WIN; c++) begin
            @(posedge clk_in); #1;
            take(1'b1, c, mask);
            @(negedge clk_in); #1;
            take(1'b0, c, mask);
         end
         for (int b = 0; b < NB; b++) begin
            int bad, dif, rs, lr, exp_rs;
            bad = 0; dif = 0; rs = rises[b*NO]; lr = 0;
            for (int i = 0; i < NO; i++) begin
               bad += bad_val[b*NO+i];
               dif += diff[b*NO+i];
               lr  += low_rise[b*NO+i];
            end
            exp_rs = !mask[b] ? 0 : (rate_sel[b] ? WIN : WIN/2);
            check(dif == 0, "R1", $sformatf("vec %0d bank %0d uniform", v, b), dif, 0);
            if (!mask[b])
               check(bad == 0, "R7", $sformatf("vec %0d bank %0d disabled", v, b), bad, 0);
            else if (rate_sel[b])
               check(bad == 0, "R2", $sformatf("vec %0d bank %0d full waveform", v, b), bad, 0);
            else
               check(bad == 0, "R3", $sformatf("vec %0d bank %0d half waveform", v, b), bad, 0);
            check(rs == exp_rs, rate_sel[b] ? "R2" : "R3",
                  $sformatf("vec %0d bank %0d rising edges", v, b), rs, exp_rs);
            check(lr == 0, "R6", $sformatf("vec %0d bank %0d rise off input edge", v, b), lr, 0);
         end
         check(fan_oe[NO*NB-1:0] != '0 && fan_oe[0] == 1'b1, "R8",
               $sformatf("vec %0d bank 0 enabled", v), fan_oe[0], 1);
         for (int b = 0; b < NB; b++)
            check(fan_oe[b*NO] == (bank_cnt_sel >= 2'(b)), "R5",
                  $sformatf("vec %0d bank %0d enable decode", v, b), fan_oe[b*NO],
                  (bank_cnt_sel >= 2'(b)));
      end

      // R6: hold in mid-run while the halving register is high must re-phase it
      @(negedge clk_in); #0.5;
      hold_n = 1'b0; rate_sel = 4'b0101; bank_cnt_sel = 2'd3;
      @(negedge clk_in); #0.5;
      hold_n = 1'b1;
      for (int c = 0; c < 3; c++) @(posedge clk_in);
      @(negedge clk_in); #0.5;
      hold_n = 1'b0;
      #1;
      check(fan_clk == '0 && fan_oe == '0, "R4", "async quiet mid-run", fan_clk, 0);
      @(negedge clk_in); #0.5;
      hold_n = 1'b1;
      #0.5;
      check(fan_clk == '0, "R6", "outputs low before first edge", fan_clk, 0);
      @(posedge clk_in); #1;
      check(fan_clk == {TOT{1'b1}}, "R6", "first edge after release rises all banks",
            fan_clk, {TOT{1'b1}});
      @(negedge clk_in); #1;
      check(fan_clk == {{NO{1'b1}}, {NO{1'b0}}, {NO{1'b1}}, {NO{1'b0}}}, "R6",
            "low phase after release", fan_clk,
            {{NO{1'b1}}, {NO{1'b0}}, {NO{1'b1}}, {NO{1'b0}}});

      // R9: rate select flipped while running, both directions
      @(negedge clk_in); #0.5;
      hold_n = 1'b0; rate_sel = 4'b0000;
      @(negedge clk_in); #0.5;
      hold_n = 1'b1;
      @(posedge clk_in); @(posedge clk_in);
      @(negedge clk_in); #0.5;
      rate_sel = 4'b1111;
      @(posedge clk_in); #1;
      check(fan_clk == {TOT{1'b1}}, "R9", "switched to full, high phase", fan_clk, {TOT{1'b1}});
      @(negedge clk_in); #1;
      check(fan_clk == '0, "R9", "switched to full, low phase", fan_clk, 0);
      rate_sel = 4'b0000;
      #0.5;
      check(fan_clk == {TOT{1'b1}}, "R9", "switched back to half mid low phase",
            fan_clk, {TOT{1'b1}});

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule